// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

This block is a synchronous processor supervisor. It joins a power-fail reset stretcher to a watchdog timer and drives one reset to the processor, in both polarities. A supply-good flag arrives already thresholded. While that flag is low, reset is held. Once the flag goes high, reset stays asserted for a parameterised reset time and then releases.

After release, the block watches a strobe line from the processor. Either a rising or a falling edge on the strobe restarts the timeout. If the strobe stays quiet for the active timeout, the block issues a reset pulse that lasts the reset time.

The timeout has two phases. After any reset ends, the long timeout applies. The short timeout applies only once the first strobe edge has been seen after release, and only if short mode is selected. A stuck strobe therefore produces resets at the long interval. A disable input stops watchdog resets, but supply-based reset keeps working. Every period is a parameter counted in clock cycles.

Top module: `wdt_supervisor`

## Requirements
- R1: While `supply_ok` is low, `sys_rst_n` is low. It goes low at the latest on the third rising clock edge after `supply_ok` falls, and it stays low as long as `supply_ok` stays low.
- R2: After `supply_ok` rises, `sys_rst_n` goes high on rising edge number RST_T+2, counted from the rise. This count includes two synchronizer stages.
- R3: RST_T equals RST_SHORT_CYC when `LONG_RESET` is 0, and RST_LONG_CYC when `LONG_RESET` is 1.
- R4: A rising edge and a falling edge on `wd_strobe` each restart the timeout count.
- R5: If no strobe edge arrives within the active timeout, the block asserts reset for exactly RST_T cycles.
- R6: After every reset release, the long timeout of LONG_TMO_CYC cycles applies. With the strobe held constant, reset stays high for exactly LONG_TMO_CYC cycles, and the pulses repeat.
- R7: With `short_mode`=1, once a strobe edge has been seen after release, reset asserts on rising edge number SHORT_TMO_CYC+3 after the most recent strobe change.
- R8: With `short_mode`=0, the timeout stays LONG_TMO_CYC even after strobe edges. Reset asserts on rising edge number LONG_TMO_CYC+3 after the last strobe change.
- R9: `sys_rst` is always the exact complement of `sys_rst_n`.
- R10: While `wd_disable`=1, the watchdog issues no resets, and a low `supply_ok` still asserts reset.
- R11: Strobe edges that occur while reset is asserted are ignored. After release, the long timeout still applies.
- R12: A supply reset restarts the watchdog count. After its release, the full long timeout applies, whatever count had built up before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| supply_ok | input | 1 | Supply-good flag, asynchronous |
| wd_strobe | input | 1 | Watchdog service strobe, asynchronous |
| wd_disable | input | 1 | 1 = watchdog resets suppressed |
| short_mode | input | 1 | 1 = short timeout allowed after the first edge |
| sys_rst_n | output | 1 | Active-low reset to the processor |
| sys_rst | output | 1 | Active-high complement of sys_rst_n |

## Verification
The hardest state to reach is the short timeout phase. To enter it, reset must have just released, short mode must be on, and a strobe edge must have passed both synchronizer stages. Edges that fall inside a reset must leave the phase unchanged. The bench reaches this state by power-cycling the supply to get a known release edge, then toggling the strobe at fixed cycle offsets. In other runs it toggles the strobe while the supply is low. It then measures the exact number of cycles until the next reset assertion, which shows which phase was in force.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the watchdog and reset supervisor.
// Assumes: all consumers import it; no logic lives here.
package wdt_pkg;

    // Timeout phase: long right after reset, short after the first edge.
    typedef enum logic {
        WD_PH_LONG  = 1'b0,
        WD_PH_SHORT = 1'b1
    } wd_phase_e;

    // Bundle of asynchronous inputs brought through the synchronizer.
    typedef struct packed {
        logic supply_ok;
        logic strobe;
        logic wd_off;
        logic short_sel;
    } sup_in_t;

    localparam int SUP_IN_W = $bits(sup_in_t);

endpackage

// File: rtl/wdt_sync_bank.sv
`timescale 1ns/1ps
// Module: wdt_sync_bank
// Carries WIDTH asynchronous bits through two flops each.
// Assumes: each bit is independent; the latency of two cycles is accepted.
module wdt_sync_bank #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic st1_q;
        logic st2_q;
        // Two-stage capture of one asynchronous bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st1_q <= 1'b0;
                st2_q <= 1'b0;
            end else begin
                st1_q <= d_async[b];
                st2_q <= st1_q;
            end
        end
        assign q_sync[b] = st2_q;
    end
endmodule

// File: rtl/wdt_edge_det.sv
`timescale 1ns/1ps
// Module: wdt_edge_det
// Flags any change of a synchronized level, rising or falling.
// Assumes: the input is already synchronous to clk.
module wdt_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic edge_o
);
    logic prev_q;

    // Remember the level seen on the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level_i;
    end

    assign edge_o = level_i ^ prev_q;
endmodule

// File: rtl/wdt_rst_stretch.sv
`timescale 1ns/1ps
// Module: wdt_rst_stretch
// Holds reset while the supply is bad or a watchdog trip arrives.
// Releases it RST_T cycles after both causes have cleared.
// Assumes: supply_ok_i is synchronous; trip_i is a one-cycle pulse.
module wdt_rst_stretch #(
    parameter int RST_T = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_i,
    input  logic trip_i,
    output logic rst_active_o
);
    localparam int CW = $clog2(RST_T + 1);
    localparam logic [CW-1:0] LAST = CW'(RST_T - 1);

    logic [CW-1:0] cnt_q;
    logic          active_q;

    // Start or restart the stretch, then count down to release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
        end else if (!supply_ok_i || trip_i) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
        end else if (active_q) begin
            if (cnt_q == LAST) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign rst_active_o = active_q;
endmodule

// File: rtl/wdt_timer.sv
`timescale 1ns/1ps
// Module: wdt_timer
// Two-phase watchdog. The long limit applies after reset; the short limit
// applies after the first strobe edge, when short mode is selected.
// Assumes: LONG_TMO >= SHORT_TMO >= 2; all inputs synchronous.
module wdt_timer
    import wdt_pkg::*;
#(
    parameter int LONG_TMO  = 200,
    parameter int SHORT_TMO = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic wd_off_i,
    input  logic short_sel_i,
    input  logic edge_i,
    output logic trip_o
);
    localparam int CW = $clog2(LONG_TMO + 1);
    localparam logic [CW-1:0] LONG_LIM  = CW'(LONG_TMO - 1);
    localparam logic [CW-1:0] SHORT_LIM = CW'(SHORT_TMO - 1);

    logic [CW-1:0] cnt_q;
    wd_phase_e     phase_q;
    logic [CW-1:0] lim;

    // Select the limit in force for the current phase and mode.
    always_comb begin
        if (phase_q == WD_PH_SHORT && short_sel_i) lim = SHORT_LIM;
        else                                      lim = LONG_LIM;
    end

    assign trip_o = !hold_i && !wd_off_i && !edge_i && (cnt_q == lim);

    // Count quiet cycles; clear on edges, reset, disable and trip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= WD_PH_LONG;
        end else if (hold_i) begin
            cnt_q   <= '0;
            phase_q <= WD_PH_LONG;
        end else if (wd_off_i) begin
            cnt_q   <= '0;
        end else if (edge_i) begin
            cnt_q   <= '0;
            phase_q <= WD_PH_SHORT;
        end else if (trip_o) begin
            cnt_q   <= '0;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_supervisor.sv
`timescale 1ns/1ps
// Module: wdt_supervisor (top)
// Supply-fail reset stretcher plus two-phase watchdog, with reset driven
// in both polarities.
// Assumes: supply_ok, wd_strobe, wd_disable and short_mode are asynchronous.
module wdt_supervisor
    import wdt_pkg::*;
#(
    parameter int RST_SHORT_CYC = 20,
    parameter int RST_LONG_CYC  = 60,
    parameter bit LONG_RESET    = 1'b0,
    parameter int LONG_TMO_CYC  = 200,
    parameter int SHORT_TMO_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic wd_strobe,
    input  logic wd_disable,
    input  logic short_mode,
    output logic sys_rst_n,
    output logic sys_rst
);
    localparam int RST_T = LONG_RESET ? RST_LONG_CYC : RST_SHORT_CYC;

    sup_in_t raw_in;
    sup_in_t syn_in;
    logic [SUP_IN_W-1:0] syn_bits;
    logic supply_sync;
    logic dis_sync;
    logic strobe_edge;
    logic wd_trip;
    logic rst_active;

    assign raw_in = '{supply_ok: supply_ok, strobe: wd_strobe,
                      wd_off: wd_disable, short_sel: short_mode};

    wdt_sync_bank #(.WIDTH(SUP_IN_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_in),
        .q_sync  (syn_bits)
    );
    assign syn_in      = sup_in_t'(syn_bits);
    assign supply_sync = syn_in.supply_ok;
    assign dis_sync    = syn_in.wd_off;

    wdt_edge_det u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (syn_in.strobe),
        .edge_o  (strobe_edge)
    );

    wdt_timer #(.LONG_TMO(LONG_TMO_CYC), .SHORT_TMO(SHORT_TMO_CYC)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_i      (rst_active),
        .wd_off_i    (dis_sync),
        .short_sel_i (syn_in.short_sel),
        .edge_i      (strobe_edge),
        .trip_o      (wd_trip)
    );

    wdt_rst_stretch #(.RST_T(RST_T)) u_stretch (
        .clk          (clk),
        .rst_n        (rst_n),
        .supply_ok_i  (supply_sync),
        .trip_i       (wd_trip),
        .rst_active_o (rst_active)
    );

    assign sys_rst_n = ~rst_active;
    assign sys_rst   = rst_active;
endmodule

// File: rtl/wdt_supervisor_chk.sv
`timescale 1ns/1ps
// Module: wdt_supervisor_chk
// Property checker bound to the supervisor top.
// Assumes: signals sampled on posedge clk; rst_n gates all checks.
module wdt_supervisor_chk #(
    parameter int RST_T = 20
) (
    input logic clk,
    input logic rst_n,
    input logic sys_rst_n,
    input logic sys_rst,
    input logic supply_sync,
    input logic dis_sync,
    input logic wd_trip
);
    int lo_run;

    // Length of the current low run on the reset output.
    always_ff @(posedge clk) begin
        if (!rst_n)          lo_run <= 0;
        else if (!sys_rst_n) lo_run <= lo_run + 1;
        else                 lo_run <= 0;
    end

    assert_supply_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_sync |=> !sys_rst_n);

    assert_release_needs_supply_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> supply_sync);

    assert_pulse_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> (lo_run >= RST_T));

    assert_trip_asserts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wd_trip |=> !sys_rst_n);

    assert_complement_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst == !sys_rst_n);

    assert_disabled_no_trip_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dis_sync |-> !wd_trip);

    assert_no_trip_in_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_rst_n |-> !wd_trip);
endmodule

bind wdt_supervisor wdt_supervisor_chk #(.RST_T(RST_T)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sys_rst_n   (sys_rst_n),
    .sys_rst     (sys_rst),
    .supply_sync (supply_sync),
    .dis_sync    (dis_sync),
    .wd_trip     (wd_trip)
);

// File: tb/wdt_supervisor_tb_top.sv
`timescale 1ns/1ps
module wdt_supervisor_tb_top;
    localparam int RST_S = 20;
    localparam int RST_L = 60;
    localparam int LONG  = 200;
    localparam int SHORT = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic wd_strobe = 1'b0;
    logic wd_disable = 1'b0;
    logic short_mode = 1'b1;
    logic sys_rst_n, sys_rst, l_rst_n, l_rst;

    int n_chk = 0;
    int n_bad = 0;
    int comp_bad = 0;

    always #10 clk = ~clk;

    wdt_supervisor #(.RST_SHORT_CYC(RST_S), .RST_LONG_CYC(RST_L), .LONG_RESET(1'b0),
                     .LONG_TMO_CYC(LONG), .SHORT_TMO_CYC(SHORT)) dut_i (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wd_strobe(wd_strobe),
        .wd_disable(wd_disable), .short_mode(short_mode),
        .sys_rst_n(sys_rst_n), .sys_rst(sys_rst));

    wdt_supervisor #(.RST_SHORT_CYC(RST_S), .RST_LONG_CYC(RST_L), .LONG_RESET(1'b1),
                     .LONG_TMO_CYC(LONG), .SHORT_TMO_CYC(SHORT)) dut_long_i (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wd_strobe(wd_strobe),
        .wd_disable(wd_disable), .short_mode(short_mode),
        .sys_rst_n(l_rst_n), .sys_rst(l_rst));

    // Complement watch on both instances (R9).
    always @(negedge clk)
        if (rst_n && ((sys_rst !== ~sys_rst_n) || (l_rst !== ~l_rst_n))) comp_bad++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count negedges until sys_rst_n equals val (bounded).
    task automatic wait_level(input logic val, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (sys_rst_n !== val && n < 2000);
    endtask

    // Drop the supply, optionally toggle the strobe, raise it, time the release.
    task automatic power_cycle(input int toggles, output int n);
        @(negedge clk);
        supply_ok = 1'b0;
        repeat (3) @(negedge clk);
        check(sys_rst_n === 1'b0, "R1 low within 3 edges", int'(sys_rst_n), 0);
        for (int i = 0; i < toggles; i++) begin
            @(negedge clk);
            wd_strobe = ~wd_strobe;
            @(negedge clk);
        end
        repeat (5) @(negedge clk);
        check(sys_rst_n === 1'b0, "R1 held while supply low", int'(sys_rst_n), 0);
        supply_ok = 1'b1;
        wait_level(1'b1, n);
        check(n == RST_S + 2, "R2 release time", n, RST_S + 2);
    endtask

    task automatic t_reset_state();
        check(sys_rst_n === 1'b0 && sys_rst === 1'b1, "R9 reset state", int'(sys_rst_n), 0);
    endtask

    task automatic t_long_variant();
        int n = 0;
        @(negedge clk);
        supply_ok = 1'b1;
        while (l_rst_n !== 1'b1 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(n == RST_L + 2, "R3 long reset time", n, RST_L + 2);
        wait_level(1'b1, n);
    endtask

    task automatic t_stuck_strobe();
        int n;
        short_mode = 1'b1;
        power_cycle(0, n);
        wait_level(1'b0, n);
        check(n == LONG, "R6 first long timeout", n, LONG);
        wait_level(1'b1, n);
        check(n == RST_S, "R5 pulse width", n, RST_S);
        wait_level(1'b0, n);
        check(n == LONG, "R6 repeat at long interval", n, LONG);
        wait_level(1'b1, n);
    endtask

    task automatic t_short_mode();
        int n;
        short_mode = 1'b1;
        power_cycle(0, n);
        repeat (30) @(negedge clk);
        wd_strobe = ~wd_strobe;
        wait_level(1'b0, n);
        check(n == SHORT + 3, "R7 short timeout after edge", n, SHORT + 3);
        wait_level(1'b1, n);
        repeat (30) @(negedge clk);
        wd_strobe = ~wd_strobe;
        repeat (30) @(negedge clk);
        wd_strobe = ~wd_strobe;
        wait_level(1'b0, n);
        check(n == SHORT + 3, "R4 second edge restarts count", n, SHORT + 3);
        wait_level(1'b1, n);
    endtask

    task automatic t_long_mode();
        int n;
        short_mode = 1'b0;
        power_cycle(0, n);
        repeat (30) @(negedge clk);
        wd_strobe = ~wd_strobe;
        wait_level(1'b0, n);
        check(n == LONG + 3, "R8 long kept in long mode", n, LONG + 3);
        wait_level(1'b1, n);
        short_mode = 1'b1;
    endtask

    task automatic t_edges_in_reset();
        int n;
        short_mode = 1'b1;
        power_cycle(3, n);
        wait_level(1'b0, n);
        check(n == LONG, "R11 edges in reset ignored", n, LONG);
        wait_level(1'b1, n);
    endtask

    task automatic t_supply_restart();
        int n;
        short_mode = 1'b0;
        power_cycle(0, n);
        repeat (150) @(negedge clk);
        power_cycle(0, n);
        wait_level(1'b0, n);
        check(n == LONG, "R12 count restarted by supply reset", n, LONG);
        wait_level(1'b1, n);
        short_mode = 1'b1;
    endtask

    task automatic t_disable();
        int n;
        int lows = 0;
        wd_disable = 1'b1;
        power_cycle(0, n);
        for (int i = 0; i < LONG + RST_S + 50; i++) begin
            @(negedge clk);
            if (sys_rst_n !== 1'b1) lows++;
        end
        check(lows == 0, "R10 no watchdog reset while disabled", lows, 0);
        power_cycle(0, n);
        wd_disable = 1'b0;
    endtask

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_long_variant();
        t_stuck_strobe();
        t_short_mode();
        t_long_mode();
        t_edges_in_reset();
        t_supply_restart();
        t_disable();
        power_cycle(0, n);
        check(comp_bad == 0, "R9 complement outputs", comp_bad, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule